// File: doc/BRIEF.md
# Graphic LCD command interpreter

This block sits on the controller side of a dot-matrix graphic display module. A host drives byte writes and reads over an 8-bit bus. A select line `bus_cd` marks each byte as a command (high) or as data/parameter (low). The block latches up to two parameter bytes ahead of each command byte. It then decodes the graphic-mode command set and acts on it. These commands set the display area's base address and line width and switch the display on or off. Others load an address pointer, move single bytes to and from the display buffer, stream bytes with automatic pointer increment, and set or clear one bit of the byte at the pointer.

The display buffer is external and holds 8 KB. The block reaches it through a synchronous port whose read data comes one cycle after the read strobe. A command read with `bus_cd` high returns a status byte that the host polls before each access. A read with `bus_cd` low returns the byte most recently fetched from the buffer.

Top module: `glcd_cmd_engine`

## Requirements
- R1: A read with `bus_cd`=1 returns the status byte. Bit 0 (command ready) and bit 1 (data ready) are 1 when the block is not busy. Bit 3 is 1 when an auto mode is active and the block is not busy. All other bits are 0. After reset the status is 0x03.
- R2: Outside auto mode, a data write (`bus_cd`=0) stores a parameter. The first goes to slot P1 and the second to slot P2. Further parameter writes are dropped. Both slots return to 0x00 after every accepted command byte, so a missing parameter reads as 0x00.
- R3: Opcode 0x42 sets `gfx_base` to {P2,P1}. Opcode 0x43 sets `gfx_width` to P1.
- R4: Opcode 0x98 sets `disp_on` and opcode 0x90 clears it. `disp_on` is 0 after reset.
- R5: Opcode 0x24 loads the pointer from the low 13 bits of {P2,P1}.
- R6: Opcodes 0xC0, 0xC2 and 0xC4 write P1 to the buffer at the pointer. The pointer then steps +1, −1 or 0 respectively, wrapping modulo 8192.
- R7: Opcodes 0xC1, 0xC3 and 0xC5 fetch the byte at the pointer into the read latch. The pointer steps +1, −1 or 0. The block is busy for the two cycles after the command. A later read with `bus_cd`=0 returns the latched byte.
- R8: Opcode 0xB0 enters auto-write mode. In it, each data write stores the byte at the pointer and increments the pointer. Opcode 0xB2 or 0xB3 leaves the mode.
- R9: Opcode 0xB1 enters auto-read mode and prefetches the byte at the pointer, then increments the pointer. Each data read returns the prefetched byte and starts the next prefetch. Data writes in this mode are ignored. In either auto mode, every command byte other than 0xB2/0xB3 is ignored.
- R10: Opcode 1111_SBBB reads the byte at the pointer, sets (S=1) or clears (S=0) bit BBB of it, and writes it back. The pointer does not move. The block is busy for two cycles.
- R11: An opcode outside the set above changes no output, no buffer byte and no pointer value. Its parameters are discarded.
- R12: While the block is busy, host writes and data reads have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per byte |
| bus_rd | input | 1 | Host read strobe, one cycle per byte |
| bus_cd | input | 1 | 1 = command/status, 0 = data/parameter |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Status byte (`bus_cd`=1) or read latch (`bus_cd`=0) |
| mem_we | output | 1 | Buffer write strobe |
| mem_re | output | 1 | Buffer read strobe |
| mem_addr | output | 13 | Buffer byte address |
| mem_wdata | output | 8 | Buffer write byte |
| mem_rdata | input | 8 | Buffer read byte, valid the cycle after `mem_re` |
| addr_ptr | output | 13 | Current address pointer |
| disp_on | output | 1 | Graphics display enabled |
| gfx_base | output | 16 | Graphics area start address |
| gfx_width | output | 8 | Graphics area width in bytes per line |

## Verification
Base address, width, display enable and the pointer take their new values on the clock edge that samples the command or data strobe. The bench checks them at the next falling edge. A single read, a bit operation and every auto-read step hold the status at 0x00 for exactly the two following cycles. The read latch is compared only once the model has counted those cycles down. `bus_rdata` depends on `bus_cd` with no register in between, so it is compared before each edge against the byte presented that cycle.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

  typedef enum logic [3:0] {
    K_NONE,
    K_PTR,
    K_BASE,
    K_WIDTH,
    K_DISP,
    K_AUTO_WR,
    K_AUTO_RD,
    K_AUTO_END,
    K_XFER_WR,
    K_XFER_RD,
    K_BIT
  } cmd_kind_e;

  typedef enum logic [1:0] {
    STEP_HOLD,
    STEP_INC,
    STEP_DEC
  } step_e;

  typedef enum logic [1:0] {
    AM_OFF,
    AM_WR,
    AM_RD
  } auto_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_ISSUE,
    S_RD_CAP,
    S_BIT_ISSUE,
    S_BIT_MOD
  } eng_state_e;

  typedef struct packed {
    cmd_kind_e  kind;
    step_e      step;
    logic       flag;
    logic [2:0] bit_idx;
  } cmd_t;

  localparam int ST_CMD_RDY  = 0;
  localparam int ST_DAT_RDY  = 1;
  localparam int ST_AUTO_RDY = 3;

endpackage

// File: rtl/glcd_decode.sv
module glcd_decode
  import glcd_pkg::*;
(
  input  logic [7:0] op,
  output cmd_t       cmd
);

  always_comb begin
    cmd.kind    = K_NONE;
    cmd.step    = STEP_HOLD;
    cmd.flag    = 1'b0;
    cmd.bit_idx = op[2:0];
    if (op[7:4] == 4'hF) begin
      cmd.kind = K_BIT;
      cmd.flag = op[3];
    end else if (op[7:3] == 5'b11000 && op[2:1] != 2'b11) begin
      cmd.kind = op[0] ? K_XFER_RD : K_XFER_WR;
      case (op[2:1])
        2'b00:   cmd.step = STEP_INC;
        2'b01:   cmd.step = STEP_DEC;
        default: cmd.step = STEP_HOLD;
      endcase
    end else begin
      case (op)
        8'h24:        cmd.kind = K_PTR;
        8'h42:        cmd.kind = K_BASE;
        8'h43:        cmd.kind = K_WIDTH;
        8'h98:        begin cmd.kind = K_DISP; cmd.flag = 1'b1; end
        8'h90:        begin cmd.kind = K_DISP; cmd.flag = 1'b0; end
        8'hB0:        cmd.kind = K_AUTO_WR;
        8'hB1:        cmd.kind = K_AUTO_RD;
        8'hB2, 8'hB3: cmd.kind = K_AUTO_END;
        default:      cmd.kind = K_NONE;
      endcase
    end
  end

endmodule

// File: rtl/glcd_param_latch.sv
module glcd_param_latch #(
  parameter int DEPTH = 2,
  parameter int W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             clr,
  input  logic [W-1:0]     din,
  output logic [DEPTH*W-1:0] slots
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (push && cnt_q != CNT_W'(DEPTH))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] q;
    logic         ld;
    assign ld = push && !clr && (cnt_q == CNT_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (ld)  q <= din;
    end
    assign slots[i*W +: W] = q;
  end

endmodule

// File: rtl/glcd_engine.sv
module glcd_engine
  import glcd_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  cmd_t              cmd,
  input  logic [7:0]        p_lo,
  input  logic [7:0]        p_hi,
  input  logic              dat_wr_go,
  input  logic              dat_rd_go,
  input  logic [7:0]        dat_in,
  input  logic [7:0]        mem_rdata,
  output logic              idle,
  output auto_e             auto_mode,
  output logic [ADDR_W-1:0] ptr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [7:0]        rd_byte
);

  eng_state_e        state_q, state_d;
  auto_e             amode_q, amode_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, addr_q, addr_d, ptr_step;
  logic              we_q, we_d, re_q, re_d, bset_q, bset_d;
  logic [7:0]        wdata_q, wdata_d, rd_q, rd_d, mask;
  logic [2:0]        bidx_q, bidx_d;
  logic [15:0]       par_word;

  assign par_word = {p_hi, p_lo};
  assign mask     = 8'd1 << bidx_q;

  always_comb begin
    case (cmd.step)
      STEP_INC: ptr_step = ptr_q + 1'b1;
      STEP_DEC: ptr_step = ptr_q - 1'b1;
      default:  ptr_step = ptr_q;
    endcase
  end

  always_comb begin
    state_d = state_q;
    amode_d = amode_q;
    ptr_d   = ptr_q;
    addr_d  = addr_q;
    we_d    = 1'b0;
    re_d    = 1'b0;
    wdata_d = wdata_q;
    rd_d    = rd_q;
    bset_d  = bset_q;
    bidx_d  = bidx_q;
    case (state_q)
      S_IDLE: begin
        if (cmd_go) begin
          case (cmd.kind)
            K_PTR:      ptr_d = par_word[ADDR_W-1:0];
            K_AUTO_WR:  amode_d = AM_WR;
            K_AUTO_RD: begin
              amode_d = AM_RD;
              re_d    = 1'b1;
              addr_d  = ptr_q;
              ptr_d   = ptr_q + 1'b1;
              state_d = S_RD_ISSUE;
            end
            K_AUTO_END: amode_d = AM_OFF;
            K_XFER_WR: begin
              we_d    = 1'b1;
              addr_d  = ptr_q;
              wdata_d = p_lo;
              ptr_d   = ptr_step;
            end
            K_XFER_RD: begin
              re_d    = 1'b1;
              addr_d  = ptr_q;
              ptr_d   = ptr_step;
              state_d = S_RD_ISSUE;
            end
            K_BIT: begin
              re_d    = 1'b1;
              addr_d  = ptr_q;
              bset_d  = cmd.flag;
              bidx_d  = cmd.bit_idx;
              state_d = S_BIT_ISSUE;
            end
            default: ;
          endcase
        end else if (dat_wr_go) begin
          we_d    = 1'b1;
          addr_d  = ptr_q;
          wdata_d = dat_in;
          ptr_d   = ptr_q + 1'b1;
        end else if (dat_rd_go) begin
          re_d    = 1'b1;
          addr_d  = ptr_q;
          ptr_d   = ptr_q + 1'b1;
          state_d = S_RD_ISSUE;
        end
      end
      S_RD_ISSUE:  state_d = S_RD_CAP;
      S_RD_CAP: begin
        rd_d    = mem_rdata;
        state_d = S_IDLE;
      end
      S_BIT_ISSUE: state_d = S_BIT_MOD;
      S_BIT_MOD: begin
        we_d    = 1'b1;
        wdata_d = bset_q ? (mem_rdata | mask) : (mem_rdata & ~mask);
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      amode_q <= AM_OFF;
      ptr_q   <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      wdata_q <= '0;
      rd_q    <= '0;
      bset_q  <= 1'b0;
      bidx_q  <= '0;
    end else begin
      state_q <= state_d;
      amode_q <= amode_d;
      ptr_q   <= ptr_d;
      addr_q  <= addr_d;
      we_q    <= we_d;
      re_q    <= re_d;
      wdata_q <= wdata_d;
      rd_q    <= rd_d;
      bset_q  <= bset_d;
      bidx_q  <= bidx_d;
    end
  end

  assign idle      = (state_q == S_IDLE);
  assign auto_mode = amode_q;
  assign ptr       = ptr_q;
  assign mem_we    = we_q;
  assign mem_re    = re_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign rd_byte   = rd_q;

endmodule

// File: rtl/glcd_cmd_engine.sv
module glcd_cmd_engine
  import glcd_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int PARAM_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_cd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] addr_ptr,
  output logic              disp_on,
  output logic [15:0]       gfx_base,
  output logic [7:0]        gfx_width
);

  localparam int PW = 8;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  cmd_t                    dec_cmd;
  auto_e                   auto_mode;
  logic                    idle;
  logic                    cmd_go, par_push, dat_wr_go, dat_rd_go;
  logic [PARAM_DEPTH*PW-1:0] par_slots;
  logic [7:0]              p_lo, p_hi, rd_byte, status;

  glcd_decode u_dec (
    .op  (bus_wdata),
    .cmd (dec_cmd)
  );

  assign cmd_go    = bus_wr & bus_cd & idle &
                     ((auto_mode == AM_OFF) | (dec_cmd.kind == K_AUTO_END));
  assign par_push  = bus_wr & ~bus_cd & idle & (auto_mode == AM_OFF);
  assign dat_wr_go = bus_wr & ~bus_cd & idle & (auto_mode == AM_WR);
  assign dat_rd_go = bus_rd & ~bus_cd & idle & (auto_mode == AM_RD);

  glcd_param_latch #(.DEPTH(PARAM_DEPTH), .W(PW)) u_par (
    .clk   (clk),
    .rst_n (rst_sn),
    .push  (par_push),
    .clr   (cmd_go),
    .din   (bus_wdata),
    .slots (par_slots)
  );

  assign p_lo = par_slots[0 +: PW];
  assign p_hi = par_slots[PW +: PW];

  glcd_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_sn),
    .cmd_go    (cmd_go),
    .cmd       (dec_cmd),
    .p_lo      (p_lo),
    .p_hi      (p_hi),
    .dat_wr_go (dat_wr_go),
    .dat_rd_go (dat_rd_go),
    .dat_in    (bus_wdata),
    .mem_rdata (mem_rdata),
    .idle      (idle),
    .auto_mode (auto_mode),
    .ptr       (addr_ptr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rd_byte   (rd_byte)
  );

  // Display configuration registers
  logic        disp_q, disp_d;
  logic [15:0] base_q, base_d;
  logic [7:0]  width_q, width_d;

  always_comb begin
    disp_d  = disp_q;
    base_d  = base_q;
    width_d = width_q;
    if (cmd_go) begin
      case (dec_cmd.kind)
        K_DISP:  disp_d  = dec_cmd.flag;
        K_BASE:  base_d  = {p_hi, p_lo};
        K_WIDTH: width_d = p_lo;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      disp_q  <= 1'b0;
      base_q  <= '0;
      width_q <= '0;
    end else begin
      disp_q  <= disp_d;
      base_q  <= base_d;
      width_q <= width_d;
    end
  end

  assign disp_on   = disp_q;
  assign gfx_base  = base_q;
  assign gfx_width = width_q;

  always_comb begin
    status                = '0;
    status[ST_CMD_RDY]    = idle;
    status[ST_DAT_RDY]    = idle;
    status[ST_AUTO_RDY]   = idle & (auto_mode != AM_OFF);
  end

  assign bus_rdata = bus_cd ? status : rd_byte;

endmodule

// File: rtl/glcd_cmd_engine_chk.sv
module glcd_cmd_engine_chk
  import glcd_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              bus_wr,
  input logic              bus_cd,
  input logic [7:0]        bus_wdata,
  input logic              idle,
  input auto_e             auto_mode,
  input logic [ADDR_W-1:0] addr_ptr,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              disp_on,
  input logic [15:0]       gfx_base,
  input logic [7:0]        gfx_width
);

  logic cmd_plain;
  assign cmd_plain = idle && bus_wr && bus_cd && (auto_mode == AM_OFF);

  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!idle && bus_wr) |=> ($stable(disp_on) && $stable(gfx_base) &&
                           $stable(gfx_width) && $stable(addr_ptr)));

  // R7
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmd_plain && (bus_wdata == 8'hC1 || bus_wdata == 8'hC3 || bus_wdata == 8'hC5))
      |=> (mem_re && !idle));

  // R6
  hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmd_plain && bus_wdata == 8'hC4) |=> (mem_we && $stable(addr_ptr)));

  // R8
  auto_wr_step_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (idle && bus_wr && !bus_cd && auto_mode == AM_WR)
      |=> (mem_we && mem_addr == $past(addr_ptr) &&
           addr_ptr == ADDR_W'($past(addr_ptr) + 1'b1)));

  // R10
  bit_rmw_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmd_plain && bus_wdata[7:4] == 4'hF)
      |=> (mem_re && !idle && mem_addr == $past(addr_ptr) && $stable(addr_ptr)));

  // R10
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({mem_we, mem_re}));

endmodule

bind glcd_cmd_engine glcd_cmd_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .bus_wr    (bus_wr),
  .bus_cd    (bus_cd),
  .bus_wdata (bus_wdata),
  .idle      (idle),
  .auto_mode (auto_mode),
  .addr_ptr  (addr_ptr),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_addr  (mem_addr),
  .disp_on   (disp_on),
  .gfx_base  (gfx_base),
  .gfx_width (gfx_width)
);

// File: tb/glcd_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module glcd_cmd_engine_tb_top;

  localparam int AW   = 13;
  localparam int MASK = (1 << AW) - 1;

  logic          clk, rst_n;
  logic          bus_wr, bus_rd, bus_cd;
  logic [7:0]    bus_wdata, bus_rdata;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_addr, addr_ptr;
  logic [7:0]    mem_wdata, mem_rdata;
  logic          disp_on;
  logic [15:0]   gfx_base;
  logic [7:0]    gfx_width;

  glcd_cmd_engine #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_cd(bus_cd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .addr_ptr(addr_ptr), .disp_on(disp_on),
    .gfx_base(gfx_base), .gfx_width(gfx_width)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Buffer behind the DUT's memory port
  logic [7:0] dmem [int];
  function automatic logic [7:0] dget(input int a);
    return dmem.exists(a) ? dmem[a] : 8'h00;
  endfunction
  always @(posedge clk) begin
    if (mem_we) dmem[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= dget(int'(mem_addr));
  end

  // Reference model state
  logic [7:0] rmem [int];
  logic [7:0] pq [$];
  int   e_ptr, e_base, e_width, e_disp, e_latch, e_amode, e_busy;
  int   checks, fails;
  bit   done;

  function automatic logic [7:0] rget(input int a);
    return rmem.exists(a) ? rmem[a] : 8'h00;
  endfunction

  task automatic check(input string tag, input string name, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    int st;
    st = (e_busy > 0) ? 0 : (((e_amode != 0) ? 8 : 0) | 3);
    check(tag, "disp_on",   int'(disp_on),   e_disp);
    check(tag, "gfx_base",  int'(gfx_base),  e_base);
    check(tag, "gfx_width", int'(gfx_width), e_width);
    check(tag, "addr_ptr",  int'(addr_ptr),  e_ptr);
    if (bus_cd)
      check(tag, "status", int'(bus_rdata), st);
    else if (e_busy == 0)
      check(tag, "read_data", int'(bus_rdata), e_latch);
  endtask

  task automatic model_edge(input logic wr, input logic rd, input logic cd, input logic [7:0] d);
    bit   was_idle;
    logic [7:0] p1, p2, v;
    was_idle = (e_busy == 0);
    if (e_busy > 0) e_busy--;
    if (!was_idle) return;
    if (wr && cd) begin
      if (e_amode != 0 && d != 8'hB2 && d != 8'hB3) return;
      p1 = (pq.size() > 0) ? pq[0] : 8'h00;
      p2 = (pq.size() > 1) ? pq[1] : 8'h00;
      pq.delete();
      if (d[7:4] == 4'hF) begin
        v = rget(e_ptr);
        if (d[3]) v = v | (8'd1 << d[2:0]);
        else      v = v & ~(8'd1 << d[2:0]);
        rmem[e_ptr] = v;
        e_busy = 2;
      end else if (d >= 8'hC0 && d <= 8'hC5) begin
        if (d[0]) begin
          e_latch = int'(rget(e_ptr));
          e_busy  = 2;
        end else
          rmem[e_ptr] = p1;
        if (d[2:1] == 2'b00)      e_ptr = (e_ptr + 1) & MASK;
        else if (d[2:1] == 2'b01) e_ptr = (e_ptr - 1) & MASK;
      end else begin
        case (d)
          8'h24: e_ptr   = ((int'(p2) << 8) | int'(p1)) & MASK;
          8'h42: e_base  = (int'(p2) << 8) | int'(p1);
          8'h43: e_width = int'(p1);
          8'h98: e_disp  = 1;
          8'h90: e_disp  = 0;
          8'hB0: e_amode = 1;
          8'hB1: begin
            e_amode = 2;
            e_latch = int'(rget(e_ptr));
            e_ptr   = (e_ptr + 1) & MASK;
            e_busy  = 2;
          end
          8'hB2, 8'hB3: e_amode = 0;
          default: ;
        endcase
      end
    end else if (wr && !cd) begin
      if (e_amode == 0) begin
        if (pq.size() < 2) pq.push_back(d);
      end else if (e_amode == 1) begin
        rmem[e_ptr] = d;
        e_ptr = (e_ptr + 1) & MASK;
      end
    end else if (rd && !cd && e_amode == 2) begin
      e_latch = int'(rget(e_ptr));
      e_ptr   = (e_ptr + 1) & MASK;
      e_busy  = 2;
    end
  endtask

  task automatic step(input logic wr, input logic rd, input logic cd,
                      input logic [7:0] d, input string tag);
    bus_wr = wr; bus_rd = rd; bus_cd = cd; bus_wdata = d;
    #1;
    compare(tag);
    @(posedge clk);
    model_edge(wr, rd, cd, d);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_cd = 1'b1; bus_wdata = 8'h00;
  endtask

  task automatic cmd(input logic [7:0] op, input string tag);
    step(1'b1, 1'b0, 1'b1, op, tag);
  endtask
  task automatic par(input logic [7:0] b, input string tag);
    step(1'b1, 1'b0, 1'b0, b, tag);
  endtask
  task automatic dread(input string tag);
    step(1'b0, 1'b1, 1'b0, 8'h00, tag);
  endtask
  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1, 8'h00, tag);
  endtask
  task automatic set_ptr(input int a, input string tag);
    par(a[7:0], tag); par(a[15:8], tag); cmd(8'h24, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    e_ptr = 0; e_base = 0; e_width = 0; e_disp = 0; e_latch = 0; e_amode = 0; e_busy = 0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_cd = 1'b1; bus_wdata = 8'h00; mem_rdata = 8'h00;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(4, "R1");

    // R4 display switch
    cmd(8'h98, "R4"); cmd(8'h90, "R4"); cmd(8'h98, "R4");
    // R3 base and width
    par(8'h34, "R3"); par(8'h12, "R3"); cmd(8'h42, "R3");
    par(8'h1E, "R3"); par(8'h00, "R3"); cmd(8'h43, "R3");
    // R2 extra parameter dropped, slots cleared after a command
    par(8'h11, "R2"); par(8'h22, "R2"); par(8'h33, "R2"); cmd(8'h42, "R2");
    cmd(8'h42, "R2");
    par(8'hCD, "R2"); par(8'hAB, "R2"); cmd(8'h42, "R2");
    // R5 pointer load, upper bits dropped
    set_ptr(16'hFFFF, "R5");
    // R6 single writes with wrap
    par(8'hA5, "R6"); cmd(8'hC0, "R6");
    par(8'h5A, "R6"); cmd(8'hC2, "R6");
    par(8'h3C, "R6"); cmd(8'hC4, "R6");
    // R7 single reads
    cmd(8'hC5, "R7"); idle(2, "R7"); dread("R7");
    cmd(8'hC1, "R7"); idle(2, "R7");
    cmd(8'hC3, "R7"); idle(2, "R7"); dread("R7");
    // R12 writes during busy ignored
    cmd(8'hC5, "R12"); cmd(8'h90, "R12"); par(8'hEE, "R12"); idle(1, "R12");
    cmd(8'h42, "R12");
    // R8 auto write
    set_ptr(16'h0100, "R8");
    cmd(8'hB0, "R8"); idle(1, "R8");
    par(8'h10, "R8"); par(8'h20, "R8"); par(8'h30, "R8");
    cmd(8'h90, "R9");
    cmd(8'hB2, "R8");
    // R9 auto read
    set_ptr(16'h0100, "R9");
    cmd(8'hB1, "R9"); idle(2, "R9");
    dread("R9"); idle(2, "R9");
    dread("R9"); idle(2, "R9");
    par(8'h77, "R9");
    dread("R9"); idle(2, "R9");
    cmd(8'hB3, "R9");
    cmd(8'h43, "R9");
    // R10 bit set/clear
    set_ptr(16'h0100, "R10");
    cmd(8'hF3, "R10"); idle(2, "R10");
    cmd(8'hF4, "R10"); idle(2, "R10");
    cmd(8'hF7, "R10"); idle(2, "R10");
    cmd(8'hC5, "R10"); idle(2, "R10"); dread("R10");
    // R11 unknown opcodes
    par(8'h34, "R11"); par(8'h12, "R11"); cmd(8'h42, "R11");
    par(8'h77, "R11"); par(8'h66, "R11"); cmd(8'h55, "R11");
    cmd(8'h42, "R11");
    cmd(8'h91, "R11");
    par(8'h99, "R11"); cmd(8'hC6, "R11");
    idle(2, "R11");

    // Buffer contents against the model (R6, R8, R10)
    foreach (rmem[k]) check("R6", "buffer", int'(dget(k)), int'(rmem[k]));
    check("R11", "buffer_untouched", int'(dget(16'h0101 + 8)), 0);

    finish_run();
  end

endmodule